// File: doc/BRIEF.md
# Split-Word Link Receiver and Pattern Checker

This block sits behind a deserializer that delivers one 16-bit half-word per clock. Bit 0 of every half-word is a marker that says which half it is. The block pairs a lower half with the upper half that follows it into one 32-bit word. The 30 payload bits of that word are then compared against a local pattern generator that runs the same test sequence as the transmitter. The generator has four test sequences: fixed, rotating, counting and pseudo-random.

Each mismatch bumps a saturating error counter. A run of clean words raises a link-good flag. Every reassembled word is also decoded for its 7-bit bunch-crossing number and its error-status bit. A word whose only set payload bit is the status bit is flagged as unusable. A start pulse from configuration software clears the counters and re-arms the pairing logic and the generator.

Top module: `lk_rx_checker`

## Requirements
- R1: A half-word with bit 0 = 0 (lower) followed on the very next cycle by a half-word with bit 0 = 1 (upper) is reassembled. The result is presented as `word_data = {upper, lower}` with `word_valid` high for one cycle, starting on the clock edge after the upper half is sampled.
- R2: Three cases are alignment errors: an upper half with no lower half held, a lower half arriving while a lower half is held, and a cycle with `rx_valid` low while a lower half is held. Each one pulses `align_err` on the next edge, discards the held half and produces no word.
- R3: The payload of a word is `{upper[15:1], lower[15:1]}` (30 bits). It is compared with the generator's current value. The generator loads its seed from `pattern` at reset, at start and at each alignment error. It advances one step after each reassembled word.
- R4: Mode encoding on `mode`: 0 keeps the seed fixed; 1 rotates left by one bit per word; 2 adds one modulo 2^30 per word; 3 shifts left inserting `p[29]^p[5]^p[3]^p[0]`. In mode 3 a zero seed is replaced by 1.
- R5: A payload that differs from the expected value raises `mismatch` together with `word_valid`. It increments `err_count`, which saturates at 2^CNT_W-1.
- R6: `link_good` rises with the GOOD_RUN-th consecutive matching word. It drops on any mismatch or alignment error.
- R7: `bcid` is formed as {lower[14:10], upper[15], lower[15]}, most significant bit first. `status_bit` is upper[1]. Both are valid with `word_valid`.
- R8: `unusable` is high exactly when the payload has only the status bit set (payload = 30'h0000_8000). It is independent of the pattern comparison.
- R9: A `start` pulse clears `err_count`, `link_good`, `word_valid`, `align_err` and any held half, and reseeds the generator. A half-word presented in the same cycle as `start` is ignored.
- R10: After reset `word_valid`, `align_err`, `mismatch` and `link_good` are low and `err_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-word clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Restart pulse from configuration |
| mode | input | 2 | Test sequence select |
| pattern | input | 30 | Generator seed / fixed pattern |
| rx_valid | input | 1 | Half-word present |
| rx_data | input | 16 | Half-word, bit 0 is the half marker |
| word_valid | output | 1 | Reassembled word strobe |
| word_data | output | 32 | Reassembled word {upper, lower} |
| bcid | output | 7 | Bunch-crossing number |
| status_bit | output | 1 | Error-status bit of the word |
| unusable | output | 1 | Word carries only the status bit |
| mismatch | output | 1 | Payload differed from the expected pattern |
| align_err | output | 1 | Half-word ordering violation |
| err_count | output | CNT_W | Saturating mismatch count |
| link_good | output | 1 | GOOD_RUN clean words in a row seen |

## Verification
The bench builds the block with CNT_W = 4 and GOOD_RUN = 8. With these values the counter saturates at 15 after a burst of twenty bad words, and the link-good threshold is crossed and broken within a few dozen cycles. The ramp mode is seeded two steps below 2^30 so that the modulo wrap is reached. The random mode is seeded with zero so that the seed substitution is exercised.

// File: rtl/lk_pkg.sv
package lk_pkg;
    localparam int PAY_W      = 30;
    localparam int HALF_W     = 16;
    localparam int STATUS_POS = 15;

    typedef logic [PAY_W-1:0] pay_t;

    typedef enum logic [1:0] {
        MODE_FIXED = 2'd0,
        MODE_ROT   = 2'd1,
        MODE_COUNT = 2'd2,
        MODE_PRBS  = 2'd3
    } mode_e;

    typedef struct packed {
        logic [6:0] bcid;
        logic       status;
        logic       unusable;
    } hdr_t;

    function automatic pay_t pat_seed(mode_e m, pay_t p);
        if (m == MODE_PRBS && p == '0)
            return pay_t'(1);
        return p;
    endfunction

    function automatic pay_t pat_step(mode_e m, pay_t c);
        case (m)
            MODE_FIXED: return c;
            MODE_ROT:   return {c[PAY_W-2:0], c[PAY_W-1]};
            MODE_COUNT: return c + pay_t'(1);
            default:    return {c[PAY_W-2:0], c[29] ^ c[5] ^ c[3] ^ c[0]};
        endcase
    endfunction

    function automatic pay_t payload_of(logic [HALF_W-1:0] hi, logic [HALF_W-1:0] lo);
        return {hi[HALF_W-1:1], lo[HALF_W-1:1]};
    endfunction

    function automatic hdr_t hdr_of(pay_t p);
        hdr_t h;
        h.bcid     = {p[13:9], p[29], p[14]};
        h.status   = p[STATUS_POS];
        h.unusable = (p == (pay_t'(1) << STATUS_POS));
        return h;
    endfunction
endpackage

// File: rtl/lk_pair.sv
module lk_pair
    import lk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [HALF_W-1:0] in_half,
    output logic              word_fire,
    output logic              pair_err,
    output pay_t              word_pay,
    output logic [2*HALF_W-1:0] word_full
);
    logic              have_lo;
    logic [HALF_W-1:0] lo_q;

    always_comb begin
        word_fire = 1'b0;
        pair_err  = 1'b0;
        if (!flush) begin
            if (in_valid) begin
                if (in_half[0]) begin
                    if (have_lo) word_fire = 1'b1;
                    else         pair_err  = 1'b1;
                end else if (have_lo) begin
                    pair_err = 1'b1;
                end
            end else if (have_lo) begin
                pair_err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            have_lo <= 1'b0;
            lo_q    <= '0;
        end else if (word_fire || pair_err) begin
            have_lo <= 1'b0;
        end else if (in_valid && !in_half[0]) begin
            have_lo <= 1'b1;
            lo_q    <= in_half;
        end
    end

    assign word_pay  = payload_of(in_half, lo_q);
    assign word_full = {in_half, lo_q};
endmodule

// File: rtl/lk_patgen.sv
module lk_patgen
    import lk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  logic  step,
    input  mode_e mode,
    input  pay_t  pattern,
    output pay_t  expected
);
    pay_t cur;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cur <= pat_seed(mode, pattern);
        else if (step)
            cur <= pat_step(mode, cur);
    end

    assign expected = cur;
endmodule

// File: rtl/lk_score.sv
module lk_score #(
    parameter int CNT_W    = 16,
    parameter int GOOD_RUN = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             fire,
    input  logic             match,
    input  logic             break_run,
    output logic [CNT_W-1:0] err_count,
    output logic             link_good
);
    localparam int RUN_W = $clog2(GOOD_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(GOOD_RUN);

    logic [RUN_W-1:0] run;
    logic [RUN_W-1:0] run_nxt;

    assign run_nxt = (run < RUN_TOP) ? run + 1'b1 : run;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            err_count <= '0;
            run       <= '0;
            link_good <= 1'b0;
        end else if (break_run) begin
            run       <= '0;
            link_good <= 1'b0;
        end else if (fire) begin
            if (match) begin
                run       <= run_nxt;
                link_good <= (run_nxt == RUN_TOP);
            end else begin
                run       <= '0;
                link_good <= 1'b0;
                if (err_count != '1)
                    err_count <= err_count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lk_rx_checker.sv
module lk_rx_checker
    import lk_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int GOOD_RUN = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [29:0]      pattern,
    input  logic             rx_valid,
    input  logic [15:0]      rx_data,
    output logic             word_valid,
    output logic [31:0]      word_data,
    output logic [6:0]       bcid,
    output logic             status_bit,
    output logic             unusable,
    output logic             mismatch,
    output logic             align_err,
    output logic [CNT_W-1:0] err_count,
    output logic             link_good
);
    logic        fire;
    logic        perr;
    pay_t        pay;
    pay_t        expd;
    logic [31:0] full;
    logic        match;
    hdr_t        hdr;

    lk_pair u_pair (
        .clk       (clk),
        .rst       (rst),
        .flush     (start),
        .in_valid  (rx_valid),
        .in_half   (rx_data),
        .word_fire (fire),
        .pair_err  (perr),
        .word_pay  (pay),
        .word_full (full)
    );

    lk_patgen u_gen (
        .clk      (clk),
        .rst      (rst),
        .restart  (start | perr),
        .step     (fire),
        .mode     (mode_e'(mode)),
        .pattern  (pattern),
        .expected (expd)
    );

    assign match = (pay == expd);
    assign hdr   = hdr_of(pay);

    lk_score #(.CNT_W(CNT_W), .GOOD_RUN(GOOD_RUN)) u_score (
        .clk       (clk),
        .rst       (rst),
        .clear     (start),
        .fire      (fire),
        .match     (match),
        .break_run (perr),
        .err_count (err_count),
        .link_good (link_good)
    );

    always_ff @(posedge clk) begin
        if (rst || start) begin
            word_valid <= 1'b0;
            mismatch   <= 1'b0;
            align_err  <= 1'b0;
            word_data  <= '0;
            bcid       <= '0;
            status_bit <= 1'b0;
            unusable   <= 1'b0;
        end else begin
            word_valid <= fire;
            mismatch   <= fire & ~match;
            align_err  <= perr;
            if (fire) begin
                word_data  <= full;
                bcid       <= hdr.bcid;
                status_bit <= hdr.status;
                unusable   <= hdr.unusable;
            end
        end
    end
endmodule

// File: rtl/lk_rx_checker_sva.sv
module lk_rx_checker_sva #(
    parameter int CNT_W    = 16,
    parameter int GOOD_RUN = 256
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             word_valid,
    input logic             status_bit,
    input logic             unusable,
    input logic             mismatch,
    input logic             align_err,
    input logic [CNT_W-1:0] err_count,
    input logic             link_good
);
    a_r1_word_not_with_align: assert property (@(posedge clk) disable iff (rst)
        !(word_valid && align_err));

    a_r5_mismatch_needs_word: assert property (@(posedge clk) disable iff (rst)
        mismatch |-> word_valid);

    a_r5_count_moves_on_mismatch: assert property (@(posedge clk) disable iff (rst)
        (err_count != $past(err_count)) |-> (mismatch || $past(start)));

    a_r5_count_no_drop: assert property (@(posedge clk) disable iff (rst)
        !start |=> (err_count >= $past(err_count)));

    a_r6_good_low_on_mismatch: assert property (@(posedge clk) disable iff (rst)
        mismatch |-> !link_good);

    a_r6_good_low_on_align: assert property (@(posedge clk) disable iff (rst)
        align_err |-> !link_good);

    a_r8_unusable_has_status: assert property (@(posedge clk) disable iff (rst)
        (word_valid && unusable) |-> status_bit);

    a_r9_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (err_count == '0 && !link_good && !word_valid && !align_err));
endmodule

bind lk_rx_checker lk_rx_checker_sva #(.CNT_W(CNT_W), .GOOD_RUN(GOOD_RUN)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .word_valid (word_valid),
    .status_bit (status_bit),
    .unusable   (unusable),
    .mismatch   (mismatch),
    .align_err  (align_err),
    .err_count  (err_count),
    .link_good  (link_good)
);

// File: tb/tb_lk_rx_checker.sv
`timescale 1ns/1ps
module tb_lk_rx_checker;
    localparam int CW = 4;
    localparam int GR = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [29:0]   pattern = '0;
    logic          rx_valid = 1'b0;
    logic [15:0]   rx_data = '0;
    logic          word_valid;
    logic [31:0]   word_data;
    logic [6:0]    bcid;
    logic          status_bit;
    logic          unusable;
    logic          mismatch;
    logic          align_err;
    logic [CW-1:0] err_count;
    logic          link_good;

    always #10 clk = ~clk;

    lk_rx_checker #(.CNT_W(CW), .GOOD_RUN(GR)) dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .pattern(pattern),
        .rx_valid(rx_valid), .rx_data(rx_data), .word_valid(word_valid),
        .word_data(word_data), .bcid(bcid), .status_bit(status_bit),
        .unusable(unusable), .mismatch(mismatch), .align_err(align_err),
        .err_count(err_count), .link_good(link_good)
    );

    typedef struct {
        logic [31:0]   word;
        logic [6:0]    bc;
        logic          st;
        logic          un;
        logic          mm;
        logic [CW-1:0] cnt;
        logic          good;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;

    logic [29:0]   m_cur;
    logic [1:0]    m_mode;
    logic [29:0]   m_pat;
    logic [CW-1:0] m_cnt;
    int            m_run;
    logic          m_good;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [29:0] b_seed(logic [1:0] m, logic [29:0] p);
        if (m == 2'd3 && p == 30'd0) return 30'd1;
        return p;
    endfunction

    // R4: independent sequence model
    function automatic logic [29:0] b_next(logic [1:0] m, logic [29:0] c);
        logic [29:0] r;
        case (m)
            2'd0: r = c;
            2'd1: r = (c << 1) | (c >> 29);
            2'd2: r = c + 30'd1;
            default: r = (c << 1) | {29'd0, ^(c & 30'h2000_0029)};
        endcase
        return r;
    endfunction

    task automatic model_restart();
        m_cur  = b_seed(m_mode, m_pat);
        m_run  = 0;
        m_good = 1'b0;
    endtask

    task automatic send_word(input logic [29:0] pay);
        item_t it;
        logic [15:0] lo, up;
        lo = {pay[14:0], 1'b0};
        up = {pay[29:15], 1'b1};
        it.word = {up, lo};
        it.bc   = {lo[14:10], up[15], lo[15]};
        it.st   = up[1];
        it.un   = up[1] && (up[15:2] == 14'd0) && (lo[15:1] == 15'd0);
        it.mm   = (pay != m_cur);
        if (it.mm) begin
            if (m_cnt != {CW{1'b1}}) m_cnt = m_cnt + 1'b1;
            m_run  = 0;
            m_good = 1'b0;
        end else begin
            if (m_run < GR) m_run++;
            m_good = (m_run >= GR);
        end
        it.cnt  = m_cnt;
        it.good = m_good;
        m_cur   = b_next(m_mode, m_cur);
        @(posedge clk); #1; rx_valid = 1'b1; rx_data = lo;
        @(posedge clk); #1; rx_data = up;
        q.push_back(it);
    endtask

    task automatic send_good(input int n);
        for (int i = 0; i < n; i++) send_word(m_cur);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; rx_valid = 1'b0;
        end
    endtask

    task automatic do_start(input logic [1:0] m, input logic [29:0] p);
        @(posedge clk); #1; rx_valid = 1'b0; start = 1'b1; mode = m; pattern = p;
        @(posedge clk); #1; start = 1'b0;
        m_mode = m; m_pat = p; m_cnt = '0;
        model_restart();
        @(negedge clk);
        chk(err_count == '0, "R9 count cleared", 32'(err_count), 0);
        chk(link_good == 1'b0, "R9 good cleared", 32'(link_good), 0);
    endtask

    // kind 0: lone upper, 1: two lowers, 2: lower then gap
    task automatic align_case(input int kind);
        @(posedge clk); #1; rx_valid = 1'b1;
        rx_data = (kind == 0) ? 16'h1235 : 16'h4420;
        if (kind == 1) begin
            @(posedge clk); #1; rx_data = 16'h0040;
        end
        @(posedge clk); #1; rx_valid = 1'b0;
        if (kind == 2) @(posedge clk);
        @(negedge clk);
        chk(align_err == 1'b1, "R2 align_err pulse", 32'(align_err), 1);
        chk(word_valid == 1'b0, "R2 no word", 32'(word_valid), 0);
        chk(link_good == 1'b0, "R6 good dropped on align", 32'(link_good), 0);
        model_restart();
        @(negedge clk);
        chk(align_err == 1'b0, "R2 single pulse", 32'(align_err), 0);
    endtask

    always @(negedge clk) begin
        if (!rst && word_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R1 unexpected word", word_data, 0);
            end else begin
                item_t it;
                it = q.pop_front();
                chk(word_data == it.word, "R1 R3 word", word_data, it.word);
                chk(bcid == it.bc, "R7 bcid", 32'(bcid), 32'(it.bc));
                chk(status_bit == it.st, "R7 status", 32'(status_bit), 32'(it.st));
                chk(unusable == it.un, "R8 unusable", 32'(unusable), 32'(it.un));
                chk(mismatch == it.mm, "R3 R4 R5 mismatch", 32'(mismatch), 32'(it.mm));
                chk(err_count == it.cnt, "R5 err_count", 32'(err_count), 32'(it.cnt));
                chk(link_good == it.good, "R6 link_good", 32'(link_good), 32'(it.good));
            end
        end
    end

    initial begin
        #(20 * 200000);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        mode = 2'd0; pattern = 30'h2BCD_1234;
        m_mode = 2'd0; m_pat = 30'h2BCD_1234; m_cnt = '0;
        model_restart();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(word_valid == 1'b0, "R10 word_valid", 32'(word_valid), 0);
        chk(align_err == 1'b0, "R10 align_err", 32'(align_err), 0);
        chk(mismatch == 1'b0, "R10 mismatch", 32'(mismatch), 0);
        chk(err_count == '0, "R10 err_count", 32'(err_count), 0);
        chk(link_good == 1'b0, "R10 link_good", 32'(link_good), 0);

        // R1 R6 fixed pattern, threshold then a bad word
        send_good(GR + 1);
        send_word(30'h2BCD_1235);
        send_good(3);
        idle(2);

        // R4 counting mode across the wrap
        do_start(2'd2, 30'h3FFF_FFFE);
        send_good(10);
        // R4 rotating mode
        do_start(2'd1, 30'h2000_0001);
        send_good(10);
        // R4 pseudo-random mode with zero seed
        do_start(2'd3, 30'd0);
        send_good(12);
        idle(2);

        // R2 alignment errors, generator reseeds (R3)
        align_case(0);
        send_good(3);
        idle(1);
        align_case(1);
        send_good(2);
        idle(1);
        align_case(2);
        send_good(2);
        idle(2);

        // R7 R8 header decoding
        do_start(2'd0, 30'h0000_8000);
        send_good(1);
        do_start(2'd0, 30'h2001_5A00);
        send_good(1);
        send_word(30'h0000_8000);
        send_word(30'h0000_C000);
        idle(2);

        // R5 saturation
        send_word(30'h1);
        for (int i = 0; i < 20; i++) send_word(30'h1 + 30'(i));
        idle(2);
        do_start(2'd0, 30'h0F0F_0F0F);

        // R9 half-word in the start cycle is ignored
        @(posedge clk); #1; rx_valid = 1'b1; rx_data = 16'h8000;
        @(posedge clk); #1; start = 1'b1; rx_data = 16'h0001;
        @(posedge clk); #1; start = 1'b0; rx_valid = 1'b0;
        model_restart();
        @(negedge clk);
        chk(word_valid == 1'b0, "R9 no word from start cycle", 32'(word_valid), 0);
        chk(align_err == 1'b0, "R9 held half dropped", 32'(align_err), 0);
        @(negedge clk);
        chk(align_err == 1'b0, "R9 no later align error", 32'(align_err), 0);
        send_good(2);
        idle(3);
        chk(q.size() == 0, "R1 all words seen", 32'(q.size()), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule